// File: doc/BRIEF.md
# Synchronous Serial Port Register Front End

This block sits between a simple memory-mapped register bus and the serial shift engine of a synchronous serial port. Software sees two registers: a control word and a 16-bit data word. Writes to the data word queue frames for transmission. Reads of the data word drain frames that the shifter has received. The shifter is outside the block and trades frames with it over a valid/ready handshake. An 8-entry queue buffers each direction.

The control word holds four settings: loopback, port enable, master/slave role and a slave-side output inhibit. The role bit is frozen while the port is enabled. The block routes the serial lines for the selected role. It feeds the shifter's own output back to its input when loopback is set. It also controls the output enables of both data pins. A 4-bit frame length input (length minus one, 4 to 16 bits) masks transmit frames on their way to the shifter and received frames on their way into the receive queue. Reads therefore return right-justified data with zero fill. Two status flags (transmit queue not full, receive queue not empty) and a sticky receive overrun flag come out as ports.

Top module: `ssp_frontend`

## Requirements
- R1: After reset, the control word reads 0, the transmit-not-full flag is 1, the receive-not-empty flag is 0 and the overrun flag is 0.
- R2: The control register is word index 0. Writing it stores bit 0 (loopback), bit 1 (enable) and bit 3 (slave output inhibit). Bits 31:4 are ignored and always read as 0.
- R3: Bit 2 of the control word (0 = master, 1 = slave) takes a written value only if the stored enable bit is 0 at the time of the write. Otherwise it keeps its value.
- R4: A write to the data register (word index 1) queues a frame. When the port is enabled and the transmit queue was empty, `tx_valid` is high in the cycle after the write. Frames leave in write order, one per cycle in which `tx_valid` and `tx_ready` are both high.
- R5: While the enable bit is 0, `tx_valid` and `rx_ready` stay low and frames offered on `rx_valid` are not queued. Data writes are still queued.
- R6: The transmit queue holds 8 frames. When it is full, `tx_not_full` is 0 and further data writes are dropped.
- R7: A data register read returns the oldest received frame in bits 15:0 with bits 31:16 zero, and removes that frame. A read with an empty receive queue returns 0 and changes nothing.
- R8: A length code n (3 to 15) selects n+1-bit frames. `tx_data` carries only the low n+1 bits of the queued frame. Received frames are stored with the bits above n+1 forced to 0.
- R9: A frame that arrives while the receive queue holds 8 frames is discarded and sets `rx_overrun`, which stays set until reset.
- R10: With loopback set, `sh_sdi` follows `sh_sdo`. Otherwise it follows `miso_i` in master role and `mosi_i` in slave role.
- R11: In master role with the port enabled, `mosi_oe` is 1 and `mosi_o` follows `sh_sdo`, whatever the inhibit bit says. In slave role with the port enabled, `miso_o` follows `sh_sdo` and `miso_oe` is 1 unless the inhibit bit is set. Both enables are 0 while the port is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 control, 1 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| cfg_len | input | 4 | Frame length minus one |
| tx_not_full | output | 1 | Transmit queue has room |
| rx_not_empty | output | 1 | Receive queue holds a frame |
| rx_overrun | output | 1 | Sticky receive overrun |
| port_en | output | 1 | Enable bit to the shifter |
| port_slave | output | 1 | Role bit to the shifter |
| tx_valid | output | 1 | Frame offered to the shifter |
| tx_ready | input | 1 | Shifter takes the frame |
| tx_data | output | 16 | Masked transmit frame |
| rx_valid | input | 1 | Shifter offers a received frame |
| rx_ready | output | 1 | Block accepts received frames |
| rx_data | input | 16 | Received frame |
| sh_sdo | input | 1 | Shifter serial output |
| sh_sdi | output | 1 | Shifter serial input |
| mosi_i | input | 1 | Master-out pin, input side |
| mosi_o | output | 1 | Master-out pin, output side |
| mosi_oe | output | 1 | Master-out pin drive enable |
| miso_i | input | 1 | Master-in pin, input side |
| miso_o | output | 1 | Master-in pin, output side |
| miso_oe | output | 1 | Master-in pin drive enable |

## Verification
The bench builds the block with its defaults: 16-bit data, 8-entry queues and a 4-bit length code. With 8 entries, full-queue drops and receive overrun come up within a few dozen cycles of random traffic. The length code covers every frame size from 4 to 16 bits. Random blocks therefore draw a new length every 500 operations, so that masking is exercised on queued frames at many sizes.

// File: rtl/ssp_fe_pkg.sv
package ssp_fe_pkg;

    localparam int CTRL_W = 4;

    // Control word layout, bit 0 at the right
    typedef struct packed {
        logic sod;    // bit 3: slave output inhibit
        logic slave;  // bit 2: role select
        logic en;     // bit 1: port enable
        logic lbm;    // bit 0: loopback
    } ssp_ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1
    } ssp_reg_e;

endpackage

// File: rtl/ssp_fe_fifo.sv
module ssp_fe_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);
    assign head  = mem_q[st_q.rp];

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        if (push_ok) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        if (pop_ok)  st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= wdata;
    end

    // R6: a push into a full queue without a pop leaves the fill level alone
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(st_q.cnt));

    // R7: popping an empty queue keeps it empty
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/ssp_fe_ctrl.sv
module ssp_fe_ctrl
    import ssp_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output ssp_ctrl_t         ctrl_q
);
    ssp_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.lbm = wdata[0];
            ctrl_d.en  = wdata[1];
            ctrl_d.sod = wdata[3];
            if (!ctrl_q.en) ctrl_d.slave = wdata[2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // R3: the role bit cannot move while the port is enabled
    a_r3_mode_lock: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.en |=> $stable(ctrl_q.slave));

endmodule

// File: rtl/ssp_fe_pinmux.sv
module ssp_fe_pinmux
    import ssp_fe_pkg::*;
(
    input  ssp_ctrl_t ctrl,
    input  logic      sh_sdo,
    output logic      sh_sdi,
    input  logic      mosi_i,
    output logic      mosi_o,
    output logic      mosi_oe,
    input  logic      miso_i,
    output logic      miso_o,
    output logic      miso_oe
);
    logic pin_in;

    always_comb begin
        pin_in  = ctrl.slave ? mosi_i : miso_i;
        sh_sdi  = ctrl.lbm ? sh_sdo : pin_in;
        mosi_o  = ctrl.slave ? 1'b0 : sh_sdo;
        miso_o  = ctrl.slave ? sh_sdo : 1'b0;
        mosi_oe = ctrl.en && !ctrl.slave;
        miso_oe = ctrl.en && ctrl.slave && !ctrl.sod;
    end

endmodule

// File: rtl/ssp_frontend.sv
module ssp_frontend
    import ssp_fe_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int BUS_W      = 32,
    parameter int LEN_W      = 4,
    parameter int ADDR_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic              tx_not_full,
    output logic              rx_not_empty,
    output logic              rx_overrun,
    output logic              port_en,
    output logic              port_slave,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              sh_sdo,
    output logic              sh_sdi,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe
);
    localparam int DATA_PAD = BUS_W - DATA_W;
    localparam int CTRL_PAD = BUS_W - CTRL_W;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA);

    typedef struct packed {
        logic ovr;
    } top_state_t;

    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] code);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = (i <= int'(code));
        return m;
    endfunction

    ssp_ctrl_t   ctrl;
    top_state_t  st_d, st_q;
    logic        ctrl_wr, data_wr, data_rd;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] tx_head, rx_head;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic        tx_pop, rx_push;
    wire         unused_hi = ^bus_wdata[BUS_W-1:DATA_W];

    assign ctrl_wr = bus_sel &&  bus_wr && (bus_addr == A_CTRL);
    assign data_wr = bus_sel &&  bus_wr && (bus_addr == A_DATA);
    assign data_rd = bus_sel && !bus_wr && (bus_addr == A_DATA);
    assign mask    = len_mask(cfg_len);

    ssp_fe_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wdata  (bus_wdata[CTRL_W-1:0]),
        .ctrl_q (ctrl)
    );

    ssp_fe_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (data_wr),
        .wdata (bus_wdata[DATA_W-1:0]),
        .pop   (tx_pop),
        .head  (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    ssp_fe_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_data & mask),
        .pop   (data_rd),
        .head  (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    ssp_fe_pinmux u_pins (
        .ctrl    (ctrl),
        .sh_sdo  (sh_sdo),
        .sh_sdi  (sh_sdi),
        .mosi_i  (mosi_i),
        .mosi_o  (mosi_o),
        .mosi_oe (mosi_oe),
        .miso_i  (miso_i),
        .miso_o  (miso_o),
        .miso_oe (miso_oe)
    );

    always_comb begin
        port_en      = ctrl.en;
        port_slave   = ctrl.slave;
        tx_valid     = ctrl.en && !tx_empty;
        tx_data      = tx_valid ? (tx_head & mask) : '0;
        tx_pop       = tx_valid && tx_ready;
        rx_ready     = ctrl.en;
        rx_push      = rx_valid && rx_ready;
        tx_not_full  = !tx_full;
        rx_not_empty = !rx_empty;
        rx_overrun   = st_q.ovr;
        bus_rdata    = '0;
        if (bus_addr == A_CTRL)
            bus_rdata = {{CTRL_PAD{1'b0}}, ctrl};
        else if (bus_addr == A_DATA && !rx_empty)
            bus_rdata = {{DATA_PAD{1'b0}}, rx_head};
    end

    always_comb begin
        st_d = st_q;
        if (rx_push && rx_full && !data_rd) st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: once set, the overrun flag stays set
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun);

    // R4: an offered frame stays offered until taken, unless control is rewritten
    a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !ctrl_wr) |=> tx_valid);

endmodule

// File: tb/tb_ssp_frontend.sv
module tb_ssp_frontend;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [3:0]  cfg_len = 4'd15;
    logic        tx_not_full, rx_not_empty, rx_overrun, port_en, port_slave;
    logic        tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
    logic [15:0] tx_data, rx_data = 0;
    logic        sh_sdo = 0, sh_sdi, mosi_i = 0, mosi_o, mosi_oe, miso_i = 0, miso_o, miso_oe;

    int n_chk = 0, n_fail = 0;
    logic [15:0] txq[$];
    logic [15:0] rxq[$];
    bit m_en = 0, m_ovr = 0;

    always #5 clk = ~clk;

    ssp_frontend dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_len(cfg_len),
        .tx_not_full(tx_not_full), .rx_not_empty(rx_not_empty), .rx_overrun(rx_overrun),
        .port_en(port_en), .port_slave(port_slave), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .sh_sdo(sh_sdo), .sh_sdi(sh_sdi), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    function automatic logic [15:0] mask_f(input logic [3:0] code);
        return 16'((32'd1 << (int'(code) + 1)) - 1);
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag);
        check({tag, " tx_not_full"}, 32'(tx_not_full), 32'(txq.size() < 8));
        check({tag, " rx_not_empty"}, 32'(rx_not_empty), 32'(rxq.size() > 0));
        check({tag, " rx_overrun"}, 32'(rx_overrun), 32'(m_ovr));
    endtask

    task automatic do_reset();
        rst_n = 0; bus_sel = 0; bus_wr = 0; tx_ready = 0; rx_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        txq.delete(); rxq.delete(); m_en = 0; m_ovr = 0;
        #1;
    endtask

    // all tasks start and end just after a falling edge
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        if (a == 2'd0) m_en = d[1];
        if (a == 2'd1 && txq.size() < 8) txq.push_back(d[15:0]);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        #1;
    endtask

    task automatic read_ctrl(input string tag, input logic [31:0] exp);
        bus_sel = 1; bus_wr = 0; bus_addr = 2'd0; #1;
        check({tag, " control read"}, bus_rdata, exp);
        @(negedge clk);
        bus_sel = 0; #1;
    endtask

    task automatic read_data(input string tag);
        logic [31:0] exp;
        bus_sel = 1; bus_wr = 0; bus_addr = 2'd1; #1;
        exp = (rxq.size() > 0) ? {16'h0, rxq[0]} : 32'h0;
        check({tag, " data read"}, bus_rdata, exp);
        if (rxq.size() > 0) void'(rxq.pop_front());
        @(negedge clk);
        bus_sel = 0; #1;
        chk_flags(tag);
    endtask

    task automatic step(input bit rdy, input bit rv, input logic [15:0] rd, input string tag);
        bit ev;
        tx_ready = rdy; rx_valid = rv; rx_data = rd; #1;
        ev = m_en && (txq.size() > 0);
        check({tag, " tx_valid"}, 32'(tx_valid), 32'(ev));
        check({tag, " rx_ready"}, 32'(rx_ready), 32'(m_en));
        if (ev) check({tag, " tx_data"}, 32'(tx_data), 32'(txq[0] & mask_f(cfg_len)));
        if (ev && rdy) void'(txq.pop_front());
        if (rv && m_en) begin
            if (rxq.size() < 8) rxq.push_back(rd & mask_f(cfg_len));
            else m_ovr = 1;
        end
        @(negedge clk);
        tx_ready = 0; rx_valid = 0; #1;
        chk_flags(tag);
    endtask

    task automatic pins(input string tag, input bit so, input bit mi, input bit si,
                        input bit e_sdi, input bit e_mo, input bit e_moe, input bit e_so, input bit e_soe);
        sh_sdo = so; mosi_i = mi; miso_i = si; #1;
        check({tag, " sh_sdi"}, 32'(sh_sdi), 32'(e_sdi));
        check({tag, " mosi_o"}, 32'(mosi_o), 32'(e_mo));
        check({tag, " mosi_oe"}, 32'(mosi_oe), 32'(e_moe));
        check({tag, " miso_o"}, 32'(miso_o), 32'(e_so));
        check({tag, " miso_oe"}, 32'(miso_oe), 32'(e_soe));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R1 reset state
        read_ctrl("R1", 32'h0);
        chk_flags("R1");
        read_data("R1 empty");

        // R2 reserved bits ignored, stored bits read back
        bus_write(0, 32'hFFFF_FFF0); read_ctrl("R2", 32'h0);
        bus_write(0, 32'hFFFF_FFFB); read_ctrl("R2", 32'hB);
        bus_write(0, 32'h0);         read_ctrl("R2", 32'h0);

        // R3 role bit lock
        bus_write(0, 32'h2); bus_write(0, 32'h6); read_ctrl("R3 locked", 32'h2);
        bus_write(0, 32'h4); read_ctrl("R3 disable write", 32'h0);
        bus_write(0, 32'h4); read_ctrl("R3 free", 32'h4);
        check("R3 port_slave", 32'(port_slave), 32'h1);
        bus_write(0, 32'h0); read_ctrl("R3 back", 32'h0);

        // R10 / R11 pin routing
        bus_write(0, 32'h2);
        pins("R10 R11 master", 1, 1, 0, 0, 1, 1, 0, 0);
        pins("R10 master in", 0, 0, 1, 1, 0, 1, 0, 0);
        bus_write(0, 32'hA);
        pins("R11 master ignores inhibit", 1, 0, 0, 0, 1, 1, 0, 0);
        bus_write(0, 32'h0); bus_write(0, 32'h6);
        pins("R10 R11 slave", 1, 1, 0, 1, 0, 0, 1, 1);
        bus_write(0, 32'hE);
        pins("R11 slave inhibit", 1, 0, 1, 0, 0, 0, 1, 0);
        bus_write(0, 32'h7);
        pins("R10 loopback hi", 1, 0, 0, 1, 0, 0, 1, 1);
        pins("R10 loopback lo", 0, 1, 1, 0, 0, 0, 0, 1);
        bus_write(0, 32'h0);
        pins("R11 disabled", 1, 1, 1, 1, 0, 0, 1, 0);

        // R5 disabled port queues writes but moves nothing
        bus_write(1, 32'h1111);
        step(1, 1, 16'hBEEF, "R5 disabled");
        read_data("R5 nothing received");
        // R4 immediate start once enabled, then from an idle enabled port
        bus_write(0, 32'h2);
        step(1, 0, 0, "R4 start after enable");
        bus_write(1, 32'hA5C3);
        check("R4 tx_valid next cycle", 32'(tx_valid), 32'h1);
        check("R4 tx_data next cycle", 32'(tx_data), 32'hA5C3);
        step(0, 0, 0, "R4 held");
        step(1, 0, 0, "R4 taken");

        // R6 full transmit queue drops the ninth write
        for (int i = 0; i < 9; i++) bus_write(1, 32'(16'h0100 + i));
        check("R6 full flag", 32'(tx_not_full), 32'h0);
        for (int i = 0; i < 9; i++) step(1, 0, 0, "R6 R4 drain order");

        // R8 length masking both ways
        cfg_len = 4'd7;
        bus_write(1, 32'hFFFF_1234);
        step(1, 1, 16'hFFFF, "R8 8-bit");
        read_data("R8 zero fill");
        cfg_len = 4'd3;
        step(0, 1, 16'hABCD, "R8 4-bit");
        read_data("R8 4-bit read");
        cfg_len = 4'd15;

        // R9 overrun and R7 order
        for (int i = 0; i < 10; i++) step(0, 1, 16'(16'h2000 + i), "R9 fill");
        check("R9 overrun set", 32'(rx_overrun), 32'h1);
        for (int i = 0; i < 9; i++) read_data("R7 R9 drain");
        step(0, 0, 0, "R9 sticky");

        // random traffic
        do_reset();
        bus_write(0, 32'h2);
        for (int i = 0; i < 4000; i++) begin
            int op;
            if (i % 500 == 0) cfg_len = 4'(3 + $urandom_range(0, 12));
            op = $urandom_range(0, 9);
            if (op < 3)      bus_write(1, $urandom());
            else if (op < 5) read_data("R7 random");
            else             step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                                  16'($urandom()), "R4 R8 random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule